// File: doc/BRIEF.md
# Session Suffix Replay Feeder

This block merges the payload of several interleaved TCP sessions into one byte stream for a bank of pattern matchers. Each incoming packet arrives as a byte stream tagged with a session number and framed by first-byte and last-byte markers. The fixed-size IP and TCP header at the front of every packet is dropped, so only payload bytes reach the matchers.

A pattern can straddle two packets of one session, and packets of other sessions may arrive between them. To keep such a pattern visible, the block keeps a ring of the most recent payload bytes of every session. The ring is as deep as the longest pattern. Before a session's next packet is passed on, the block plays back whatever that ring holds, oldest byte first. While the playback runs, the input is held off.

A stream-start flag marks the first byte of every playback-plus-payload burst, so the matchers can clear or swap their partial-match state. The output uses a valid/ready handshake.

Top module: `suffix_feeder`

## Requirements
- R1: After reset `out_valid` and `in_ready` are low and no session has history, so the first packet of any session is emitted with no playback.
- R2: The first `HDR_LEN` bytes of every packet are consumed and never appear on the output.
- R3: Payload bytes (packet bytes after the header) appear on the output in arrival order, with `out_sid` equal to the packet's session number, and none is lost or duplicated.
- R4: Before the payload of a packet whose session has history, the block outputs that session's stored bytes, oldest first, with `out_sid` set to that session.
- R5: `out_sos` is 1 on the first output byte of each burst (playback byte if there is playback, else first payload byte) and 0 on every other output byte.
- R6: Histories of different sessions are independent: interleaving packets of other sessions does not change what a session plays back.
- R7: While stored bytes are being played back, `in_ready` is 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_sos` hold their values on the next cycle.
- R9: A packet of `HDR_LEN` bytes or fewer produces only its session's playback (nothing when history is empty) and leaves the history unchanged.
- R10: History saturates at `SUF_LEN` bytes. Once more payload has passed, playback consists of exactly the last `SUF_LEN` payload bytes of the session.
- R11: While waiting for a packet, any input byte without the first-byte marker (`in_sop` = 0) is accepted and discarded without output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle |
| in_data | input | 8 | Input packet byte |
| in_sid | input | SID_W | Session number of the packet |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_sid | output | SID_W | Session the output byte belongs to |
| out_sos | output | 1 | First byte of a burst |

## Verification
The assertions assume a well-formed input. Each packet opens with `in_sop` on its first byte and closes with `in_eop` on its last. `in_sid` is below `NUM_SESS` and does not change inside a packet. `in_valid` stays high until the byte is taken. The bench builds every packet through a single driver task that sets these markers from the packet length and holds each byte until the handshake completes. Its only deliberate departure is a stray unmarked byte sent between packets to exercise R11. The bench also toggles `out_ready` pseudo-randomly in some phases so that playback and payload both meet back-pressure.

// File: rtl/feed_pkg.sv
package feed_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_REPLAY = 2'd1,
    ST_PASS   = 2'd2
  } feed_state_e;

  // (base + ofs) modulo depth, for ofs < depth
  function automatic int unsigned ring_add(int unsigned base, int unsigned ofs,
                                           int unsigned depth);
    int unsigned s;
    s = base + ofs;
    return (s >= depth) ? s - depth : s;
  endfunction

  // (base - ofs) modulo depth, for ofs <= depth
  function automatic int unsigned ring_sub(int unsigned base, int unsigned ofs,
                                           int unsigned depth);
    return (base >= ofs) ? base - ofs : base + depth - ofs;
  endfunction

  // flat index of a byte in the shared store
  function automatic int unsigned slot_addr(int unsigned sid, int unsigned pos,
                                            int unsigned depth);
    return sid * depth + pos;
  endfunction

endpackage

// File: rtl/suffix_store.sv
module suffix_store
  import feed_pkg::*;
#(
  parameter int NUM_SESS = 4,
  parameter int DEPTH    = 257,
  parameter int SID_W    = 2,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [SID_W-1:0] sel_sid,
  input  logic [CNT_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] hist_len
);

  localparam int TOTAL  = NUM_SESS * DEPTH;
  localparam int ADDR_W = $clog2(TOTAL);

  logic [CNT_W-1:0] wptr [NUM_SESS];
  logic [CNT_W-1:0] fill [NUM_SESS];
  logic [7:0]       mem  [TOTAL];

  for (genvar s = 0; s < NUM_SESS; s++) begin : g_sess
    logic [CNT_W-1:0] wp_q;
    logic [CNT_W-1:0] fl_q;
    logic             hit;

    assign hit = wr_en && (32'(sel_sid) == s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp_q <= '0;
        fl_q <= '0;
      end else if (hit) begin
        wp_q <= CNT_W'(ring_add(32'(wp_q), 1, DEPTH));
        if (32'(fl_q) != DEPTH) fl_q <= fl_q + CNT_W'(1);
      end
    end

    assign wptr[s] = wp_q;
    assign fill[s] = fl_q;
  end

  logic [CNT_W-1:0]  cur_wptr;
  logic [CNT_W-1:0]  oldest;
  logic [CNT_W-1:0]  rd_pos;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;

  assign cur_wptr = wptr[sel_sid];
  assign hist_len = fill[sel_sid];
  assign oldest   = CNT_W'(ring_sub(32'(cur_wptr), 32'(hist_len), DEPTH));
  assign rd_pos   = CNT_W'(ring_add(32'(oldest), 32'(rd_ofs), DEPTH));
  assign wr_addr  = ADDR_W'(slot_addr(32'(sel_sid), 32'(cur_wptr), DEPTH));
  assign rd_addr  = ADDR_W'(slot_addr(32'(sel_sid), 32'(rd_pos), DEPTH));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/feed_ctrl.sv
module feed_ctrl
  import feed_pkg::*;
#(
  parameter int SID_W   = 2,
  parameter int CNT_W   = 9,
  parameter int HDR_LEN = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [SID_W-1:0] in_sid,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [SID_W-1:0] out_sid,
  output logic             out_sos,
  input  logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] hist_len,
  output logic [SID_W-1:0] sel_sid,
  output logic [CNT_W-1:0] rd_ofs,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             replay_active,
  output logic             hdr_drop
);

  localparam int HDR_W = $clog2(HDR_LEN + 1);

  feed_state_e      st_q;
  logic [SID_W-1:0] sid_q;
  logic [CNT_W-1:0] ofs_q;
  logic [CNT_W-1:0] len_q;
  logic [HDR_W-1:0] hcnt_q;
  logic             first_q;

  logic pass_st;
  logic in_take;
  logic last_rep;

  assign pass_st       = (st_q == ST_PASS);
  assign replay_active = (st_q == ST_REPLAY);
  assign hdr_drop      = pass_st && (hcnt_q < HDR_W'(HDR_LEN));
  assign last_rep      = (ofs_q == len_q - CNT_W'(1));

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = in_data;
    unique case (st_q)
      ST_WAIT:   in_ready = in_valid && !in_sop;
      ST_REPLAY: begin
        out_valid = 1'b1;
        out_data  = rd_data;
      end
      ST_PASS: begin
        if (hdr_drop) begin
          in_ready = 1'b1;
        end else begin
          out_valid = in_valid;
          in_ready  = out_ready;
        end
      end
      default: ;
    endcase
  end

  assign in_take = in_valid && in_ready;
  assign out_sos = out_valid && first_q;
  assign out_sid = sid_q;
  assign sel_sid = (st_q == ST_WAIT) ? in_sid : sid_q;
  assign rd_ofs  = ofs_q;
  assign wr_en   = pass_st && !hdr_drop && in_valid && out_ready;
  assign wr_data = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_WAIT;
      sid_q   <= '0;
      ofs_q   <= '0;
      len_q   <= '0;
      hcnt_q  <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (in_valid && in_sop) begin
            sid_q   <= in_sid;
            ofs_q   <= '0;
            len_q   <= hist_len;
            hcnt_q  <= '0;
            first_q <= 1'b1;
            st_q    <= (hist_len != '0) ? ST_REPLAY : ST_PASS;
          end
        end
        ST_REPLAY: begin
          if (out_ready) begin
            ofs_q   <= ofs_q + CNT_W'(1);
            first_q <= 1'b0;
            if (last_rep) st_q <= ST_PASS;
          end
        end
        ST_PASS: begin
          if (in_take) begin
            if (hdr_drop) hcnt_q  <= hcnt_q + HDR_W'(1);
            else          first_q <= 1'b0;
            if (in_eop)   st_q    <= ST_WAIT;
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/suffix_feeder.sv
module suffix_feeder
  import feed_pkg::*;
#(
  parameter int NUM_SESS = 4,
  parameter int SUF_LEN  = 257,
  parameter int HDR_LEN  = 40,
  parameter int SID_W    = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic [SID_W-1:0] in_sid,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic [SID_W-1:0] out_sid,
  output logic             out_sos
);

  localparam int CNT_W = $clog2(SUF_LEN + 1);

  logic [7:0]       rd_data;
  logic [CNT_W-1:0] hist_len;
  logic [SID_W-1:0] sel_sid;
  logic [CNT_W-1:0] rd_ofs;
  logic             wr_en;
  logic [7:0]       wr_data;
  logic             replay_active;
  logic             hdr_drop;

  suffix_store #(
    .NUM_SESS (NUM_SESS),
    .DEPTH    (SUF_LEN),
    .SID_W    (SID_W),
    .CNT_W    (CNT_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sel_sid  (sel_sid),
    .rd_ofs   (rd_ofs),
    .rd_data  (rd_data),
    .hist_len (hist_len)
  );

  feed_ctrl #(
    .SID_W   (SID_W),
    .CNT_W   (CNT_W),
    .HDR_LEN (HDR_LEN)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_data       (in_data),
    .in_sid        (in_sid),
    .in_sop        (in_sop),
    .in_eop        (in_eop),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_sid       (out_sid),
    .out_sos       (out_sos),
    .rd_data       (rd_data),
    .hist_len      (hist_len),
    .sel_sid       (sel_sid),
    .rd_ofs        (rd_ofs),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .replay_active (replay_active),
    .hdr_drop      (hdr_drop)
  );

endmodule

// File: rtl/suffix_feeder_chk.sv
module suffix_feeder_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_sos,
  input logic             replay_active,
  input logic             hdr_drop,
  input logic [CNT_W-1:0] rd_ofs,
  input logic [CNT_W-1:0] hist_len
);

  // R2: header bytes never reach the output
  p_hdr_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_drop |-> !out_valid);

  // R4: playback index stays inside the stored history
  p_replay_in_hist_r4: assert property (@(posedge clk) disable iff (!rst_n)
    replay_active |-> (rd_ofs < hist_len));

  // R5: once a byte has been taken, the next cycle carries no start flag
  p_sos_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_sos);

  // R7: input held off during playback
  p_stall_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_active |-> !in_ready);

  // R8: a stalled output byte is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sos)));

endmodule

bind suffix_feeder suffix_feeder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_sos       (out_sos),
  .replay_active (replay_active),
  .hdr_drop      (hdr_drop),
  .rd_ofs        (rd_ofs),
  .hist_len      (hist_len)
);

// File: tb/tb_suffix_feeder.sv
module tb_suffix_feeder;

  localparam int NS  = 3;
  localparam int SUF = 6;
  localparam int HDR = 3;
  localparam int SW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic [SW-1:0] in_sid = '0;
  logic          in_sop = 1'b0;
  logic          in_eop = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [7:0]    out_data;
  logic [SW-1:0] out_sid;
  logic          out_sos;

  always #2 clk = ~clk;  // 250 MHz

  suffix_feeder #(.NUM_SESS(NS), .SUF_LEN(SUF), .HDR_LEN(HDR), .SID_W(SW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sid(in_sid), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sid(out_sid), .out_sos(out_sos)
  );

  typedef struct {
    logic [7:0] d;
    logic       sos;
    int         sid;
    bit         rep;
  } item_t;

  item_t      exp_q[$];
  logic [7:0] hist_buf [NS][SUF];
  int         hist_n [NS];
  int         checks = 0;
  int         errors = 0;
  int         ready_mode = 0;
  string      phase = "reset";

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(int seed, int i);
    return 8'((seed * 7 + i * 13) % 200);  // never 0xEE
  endfunction

  task automatic remember(int sid, logic [7:0] b);
    if (hist_n[sid] < SUF) begin
      hist_buf[sid][hist_n[sid]] = b;
      hist_n[sid]++;
    end else begin
      for (int k = 0; k < SUF - 1; k++) hist_buf[sid][k] = hist_buf[sid][k+1];
      hist_buf[sid][SUF-1] = b;
    end
  endtask

  task automatic drive_byte(int sid, logic [7:0] d, bit sop, bit eop);
    in_valid = 1'b1;
    in_data  = d;
    in_sid   = SW'(sid);
    in_sop   = sop;
    in_eop   = eop;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic send_pkt(int sid, int len, int seed);
    int nrep;
    item_t it;
    nrep = hist_n[sid];
    for (int i = 0; i < nrep; i++) begin
      it.d = hist_buf[sid][i]; it.sos = (i == 0); it.sid = sid; it.rep = 1'b1;
      exp_q.push_back(it);
    end
    for (int i = HDR; i < len; i++) begin
      it.d = pay(seed, i); it.sos = (nrep == 0) && (i == HDR);
      it.sid = sid; it.rep = 1'b0;
      exp_q.push_back(it);
      remember(sid, pay(seed, i));
    end
    for (int i = 0; i < len; i++)
      drive_byte(sid, (i < HDR) ? 8'hEE : pay(seed, i), i == 0, i == len - 1);
  endtask

  task automatic drain();
    for (int w = 0; w < 2000 && exp_q.size() != 0; w++) @(posedge clk);
    chk(exp_q.size() == 0, "R3 missing output bytes", exp_q.size(), 0);
  endtask

  // back-pressure source
  always @(posedge clk) begin
    #1;
    out_ready <= (ready_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
  end

  // scoreboard monitor
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data;
  logic       prev_sos;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R8 valid dropped under stall", out_valid, 1);
        chk(out_data == prev_data, "R8 data changed under stall", out_data, prev_data);
        chk(out_sos == prev_sos, "R8 sos changed under stall", out_sos, prev_sos);
      end
      if (out_valid) begin
        chk(out_data != 8'hEE, "R2 R11 header or stray byte leaked", out_data, 0);
        if (exp_q.size() != 0 && exp_q[0].rep)
          chk(in_ready == 1'b0, "R7 input taken during playback", in_ready, 0);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected output byte", out_data, -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(out_data == e.d, e.rep ? "R4 playback byte" : "R3 payload byte",
              out_data, e.d);
          chk(out_sos == e.sos, "R5 stream-start flag", out_sos, e.sos);
          chk(int'(out_sid) == e.sid, "R6 session tag", out_sid, e.sid);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_sos   = out_sos;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, 150000, 0);
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) hist_n[s] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b0, "R1 in_ready after reset", in_ready, 0);
    @(posedge clk); #1;

    phase = "R1 R3 first packet";
    send_pkt(0, HDR + 4, 1);
    drain();

    phase = "R10 saturating history";
    send_pkt(1, HDR + 10, 2);
    drain();

    phase = "R4 R6 playback of session 0";
    send_pkt(0, HDR + 5, 3);
    drain();

    phase = "R10 playback of last SUF bytes";
    send_pkt(1, HDR + 2, 4);
    drain();

    phase = "R9 short packets";
    send_pkt(2, HDR - 1, 5);
    send_pkt(2, HDR, 6);
    send_pkt(0, HDR, 7);
    send_pkt(0, HDR + 1, 8);
    drain();

    phase = "R11 stray byte";
    drive_byte(2, 8'hEE, 1'b0, 1'b0);
    send_pkt(2, HDR + 3, 9);
    drain();

    phase = "R6 R8 interleaved with back-pressure";
    ready_mode = 1;
    for (int p = 0; p < 40; p++)
      send_pkt(p % NS, 1 + (p * 5) % 12, 10 + p);
    drain();
    ready_mode = 0;
    repeat (4) @(posedge clk);
    finish_run();
  end

endmodule